// File: doc/BRIEF.md
# Compare Match Interval Timer

This peripheral produces periodic interrupt requests. It has one or two independent channels behind a 16-bit register bus. Each channel has three parts: a free-running up-counter, a compare value, and a prescaler that divides the peripheral clock by a ratio chosen per channel. When the counter reaches the compare value on a prescaled tick, it wraps to zero and sets a match flag. If the channel's interrupt enable is set, that flag raises the channel's interrupt line.

Software follows a fixed sequence. It stops the channel, loads the compare value with the desired interval, selects a divider, enables the interrupt and sets the channel's run bit. In the interrupt service it reads the control word, sees the flag at one, and writes the word back with the flag bit at zero. A zero written to the flag bit has no effect unless that read came first. A match that lands in the same cycle as the clearing write is not lost.

Top module: `cmt_timer`

## Requirements
- R1: The bus reads as follows. Address 0x0 holds the run bits (bit c runs channel c). For channel c, the control word is at 0x2+6c, the counter at 0x4+6c and the compare value at 0x6+6c. A read issued at a clock edge presents its data on `bus_rdata` after that edge, and the data holds until the next read. An unmapped address reads as zero.
- R2: While a channel's run bit is zero, its counter holds its value and its prescaler returns to zero. After a restart, the first tick therefore comes a full divider period later.
- R3: Control bits [1:0] select the count clock as the input clock divided by 8, 32, 128 or 512, for codes 0, 1, 2 and 3.
- R4: The counter advances by one per tick. On the tick where it equals the compare value, it goes to zero and control bit 7 (the match flag) sets in the same cycle. With the run bit written at edge E, the flag is first visible after edge E + ratio·(compare+1).
- R5: `irq[c]` is high exactly while channel c's match flag and its enable (control bit 6) are both one.
- R6: A write with bit 7 at zero clears the flag only if the control word was read with the flag at one since the flag was last set. A later match removes that permission.
- R7: Only a match sets the flag. Writing one to bit 7 never sets it and never clears it.
- R8: When a match and a permitted clearing write fall in the same cycle, the flag stays set.
- R9: Control bits other than 7, 6, 1 and 0 read as zero, and writes to them are ignored.
- R10: Software can write the counter, and counting continues from the written value.
- R11: The channels count, flag and interrupt independently of each other.
- R12: After reset, the run bits, the control words, the counters, `bus_rdata` and `irq` are all zero, and the compare values are all ones.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Byte address of the register |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| irq | output | NUM_CH | Interrupt request per channel |

## Verification
A compare match and a software clear of the flag can land on the same clock edge. To provoke this, the bench runs channel 0 with a compare value of zero and divider 8, so a match occurs every eighth edge. It reads the flag to arm the clear, then times the clearing write to the exact match edge. The flag must still be set after that edge. A second clearing write with no read in between must also fail to clear it, because the match withdrew the permission. Only a fresh read followed by a write clears the flag.

// File: rtl/cmt_pkg.sv
package cmt_pkg;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 16;
  localparam int FLAG_BIT = 7;
  localparam int IE_BIT   = 6;
  localparam int PRE_W    = $clog2(8 << 6);
  localparam logic [DATA_W-1:0] CTRL_MASK  = 16'h00C3;
  localparam logic [ADDR_W-1:0] START_ADDR = 4'h0;

  function automatic logic [ADDR_W-1:0] ctrl_addr(input int c);
    return ADDR_W'(2 + 6 * c);
  endfunction

  function automatic logic [ADDR_W-1:0] cnt_addr(input int c);
    return ADDR_W'(4 + 6 * c);
  endfunction

  function automatic logic [ADDR_W-1:0] cmp_addr(input int c);
    return ADDR_W'(6 + 6 * c);
  endfunction

  function automatic logic [PRE_W-1:0] pre_last(input logic [1:0] sel);
    return PRE_W'((8 << (2 * int'(sel))) - 1);
  endfunction
endpackage

// File: rtl/cmt_prescaler.sv
module cmt_prescaler
  import cmt_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       run,
  input  logic [1:0] sel,
  output logic       tick
);
  logic [PRE_W-1:0] acc;
  logic [PRE_W-1:0] last;

  always_comb last = pre_last(sel);

  // ">=" keeps the divider sane when the ratio is lowered mid-period
  assign tick = run && (acc >= last);

  always_ff @(posedge clk) begin
    if (rst || !run) acc <= '0;
    else if (tick)   acc <= '0;
    else             acc <= acc + 1'b1;
  end
endmodule

// File: rtl/cmt_channel.sv
module cmt_channel
  import cmt_pkg::*;
#(
  parameter logic [DATA_W-1:0] CMP_RST = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              run,
  input  logic              wr_ctrl,
  input  logic              wr_cnt,
  input  logic              wr_cmp,
  input  logic              rd_ctrl,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] ctrl_q,
  output logic [DATA_W-1:0] cnt_q,
  output logic [DATA_W-1:0] cmp_q,
  output logic              irq
);
  logic       flag, armed, ie;
  logic [1:0] cks;
  logic       tick, match, clr_ok;

  cmt_prescaler u_pre (
    .clk  (clk),
    .rst  (rst),
    .run  (run),
    .sel  (cks),
    .tick (tick)
  );

  assign match  = tick && !wr_cnt && (cnt_q == cmp_q);
  assign clr_ok = wr_ctrl && !wdata[FLAG_BIT] && armed && flag;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag  <= 1'b0;
      armed <= 1'b0;
      ie    <= 1'b0;
      cks   <= 2'b00;
      cnt_q <= '0;
      cmp_q <= CMP_RST;
    end else begin
      if (wr_ctrl) begin
        ie  <= wdata[IE_BIT];
        cks <= wdata[1:0];
      end
      if (wr_cmp) cmp_q <= wdata;
      if (wr_cnt)    cnt_q <= wdata;
      else if (tick) cnt_q <= match ? '0 : cnt_q + 1'b1;
      if (match) begin
        flag  <= 1'b1;
        armed <= 1'b0;
      end else if (clr_ok) begin
        flag  <= 1'b0;
        armed <= 1'b0;
      end else if (rd_ctrl && flag) begin
        armed <= 1'b1;
      end
    end
  end

  assign ctrl_q = {8'h00, flag, ie, 4'h0, cks};
  assign irq    = flag & ie;
endmodule

// File: rtl/cmt_regbus.sv
module cmt_regbus
  import cmt_pkg::*;
#(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [DATA_W-1:0] start_v,
  input  logic [DATA_W-1:0] ctrl_v [NUM_CH],
  input  logic [DATA_W-1:0] cnt_v  [NUM_CH],
  input  logic [DATA_W-1:0] cmp_v  [NUM_CH],
  output logic              wr_start,
  output logic [NUM_CH-1:0] wr_ctrl,
  output logic [NUM_CH-1:0] wr_cnt,
  output logic [NUM_CH-1:0] wr_cmp,
  output logic [NUM_CH-1:0] rd_ctrl,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] rd_val;

  always_comb begin
    wr_start = wr && (addr == START_ADDR);
    rd_val   = (addr == START_ADDR) ? start_v : '0;
    for (int c = 0; c < NUM_CH; c++) begin
      wr_ctrl[c] = wr && (addr == ctrl_addr(c));
      wr_cnt[c]  = wr && (addr == cnt_addr(c));
      wr_cmp[c]  = wr && (addr == cmp_addr(c));
      rd_ctrl[c] = rd && (addr == ctrl_addr(c));
      if (addr == ctrl_addr(c)) rd_val = ctrl_v[c];
      if (addr == cnt_addr(c))  rd_val = cnt_v[c];
      if (addr == cmp_addr(c))  rd_val = cmp_v[c];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)     rdata <= '0;
    else if (rd) rdata <= rd_val;
  end
endmodule

// File: rtl/cmt_timer.sv
module cmt_timer
  import cmt_pkg::*;
#(
  parameter int                NUM_CH  = 2,
  parameter logic [DATA_W-1:0] CMP_RST = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [3:0]        bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [15:0]       bus_wdata,
  output logic [15:0]       bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0] start_q;
  logic [DATA_W-1:0] start_v;
  logic              wr_start;
  logic [NUM_CH-1:0] wr_ctrl, wr_cnt, wr_cmp, rd_ctrl;
  logic [DATA_W-1:0] ch_ctrl [NUM_CH];
  logic [DATA_W-1:0] ch_cnt  [NUM_CH];
  logic [DATA_W-1:0] ch_cmp  [NUM_CH];

  always_ff @(posedge clk) begin
    if (rst)           start_q <= '0;
    else if (wr_start) start_q <= bus_wdata[NUM_CH-1:0];
  end

  assign start_v = DATA_W'(start_q);

  cmt_regbus #(.NUM_CH(NUM_CH)) u_bus (
    .clk      (clk),
    .rst      (rst),
    .addr     (bus_addr),
    .wr       (bus_wr),
    .rd       (bus_rd),
    .start_v  (start_v),
    .ctrl_v   (ch_ctrl),
    .cnt_v    (ch_cnt),
    .cmp_v    (ch_cmp),
    .wr_start (wr_start),
    .wr_ctrl  (wr_ctrl),
    .wr_cnt   (wr_cnt),
    .wr_cmp   (wr_cmp),
    .rd_ctrl  (rd_ctrl),
    .rdata    (bus_rdata)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    cmt_channel #(.CMP_RST(CMP_RST)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .run     (start_q[c]),
      .wr_ctrl (wr_ctrl[c]),
      .wr_cnt  (wr_cnt[c]),
      .wr_cmp  (wr_cmp[c]),
      .rd_ctrl (rd_ctrl[c]),
      .wdata   (bus_wdata),
      .ctrl_q  (ch_ctrl[c]),
      .cnt_q   (ch_cnt[c]),
      .cmp_q   (ch_cmp[c]),
      .irq     (irq[c])
    );
  end
endmodule

// File: rtl/cmt_timer_chk.sv
module cmt_timer_chk
  import cmt_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic              wbit7,
  input logic [DATA_W-1:0] bus_rdata,
  input logic              run0,
  input logic [DATA_W-1:0] cnt0,
  input logic [DATA_W-1:0] ctrl0
);
  logic flag0;
  assign flag0 = ctrl0[FLAG_BIT];

  // R2
  hold_when_stopped_chk: assert property (@(posedge clk) disable iff (rst)
    (!run0 && !(bus_wr && bus_addr == cnt_addr(0))) |=> $stable(cnt0));

  // R2
  set_needs_run_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag0) |-> $past(run0));

  // R4
  wrap_on_match_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag0) |-> (cnt0 == '0));

  // R7
  no_spurious_set_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag0 && !run0) |=> !flag0);

  // R6
  clear_by_write_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(flag0) |-> $past(bus_wr && bus_addr == ctrl_addr(0) && !wbit7));

  // R9
  unused_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl0 & ~CTRL_MASK) == '0);

  // R1
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> $stable(bus_rdata));
endmodule

bind cmt_timer cmt_timer_chk u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .wbit7     (bus_wdata[7]),
  .bus_rdata (bus_rdata),
  .run0      (start_q[0]),
  .cnt0      (ch_cnt[0]),
  .ctrl0     (ch_ctrl[0])
);

// File: tb/test_cmt_timer.sv
`timescale 1ns/1ps
module test_cmt_timer;
  localparam int NCH = 2;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic [3:0]     bus_addr = '0;
  logic           bus_wr = 1'b0;
  logic           bus_rd = 1'b0;
  logic [15:0]    bus_wdata = '0;
  logic [15:0]    bus_rdata;
  logic [NCH-1:0] irq;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  typedef struct {
    logic [15:0] v;
    string       tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;

  cmt_timer #(.NUM_CH(NCH)) i_cmt_timer (
    .clk       (clk),
    .rst       (rst),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq       (irq)
  );

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // each bus task spans exactly one rising edge, starting and ending at a falling edge
  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [15:0] exp, input string tag);
    item_t it;
    it.v = exp; it.tag = tag;
    sb.push_back(it);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // monitor: compares each read result against the queued expectation
  initial begin
    forever begin
      @(posedge clk);
      if (bus_rd) begin
        @(negedge clk);
        if (sb.size() == 0) begin
          n_chk++; n_fail++;
          $display("FAIL R1: actual %h expected none queued", bus_rdata);
        end else begin
          item_t it;
          it = sb.pop_front();
          chk(bus_rdata, it.v, it.tag);
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12: watchdog expired, actual running expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    idle(4);
    rst = 1'b0;

    // R12 reset state
    chk(16'(irq), 16'h0000, "R12 irq after reset");
    rd(4'h0, 16'h0000, "R12 run bits");
    rd(4'h2, 16'h0000, "R12 ctrl0");
    rd(4'h4, 16'h0000, "R12 cnt0");
    rd(4'h6, 16'hFFFF, "R12 cmp0");
    rd(4'hA, 16'h0000, "R12 cnt1");
    rd(4'hE, 16'h0000, "R1 unmapped");
    rd(4'hC, 16'hFFFF, "R12 cmp1");
    idle(3);
    chk(bus_rdata, 16'hFFFF, "R1 rdata holds");

    // R10 / R2: counter writable and held while stopped
    wr(4'h4, 16'h0005);
    idle(10);
    rd(4'h4, 16'h0005, "R10 cnt written and held");

    // R4 / R3 / R5: divider 8, compare 3 -> flag after 32 edges
    wr(4'h6, 16'h0003);
    wr(4'h2, 16'h0040);
    wr(4'h4, 16'h0000);
    wr(4'h0, 16'h0001);          // edge E0
    idle(19);
    rd(4'h4, 16'h0002, "R4 count mid period");  // edge E0+20
    idle(11);
    chk(16'(irq[0]), 16'h0000, "R4 no flag before period");
    idle(1);
    chk(16'(irq[0]), 16'h0001, "R5 irq at period end");
    wr(4'h0, 16'h0000);
    rd(4'h4, 16'h0000, "R4 counter wrapped to zero");

    // R6 / R7: clear protocol
    wr(4'h2, 16'h0040);
    chk(16'(irq[0]), 16'h0001, "R6 clear without read ignored");
    rd(4'h2, 16'h00C0, "R4 flag bit 7 set");
    wr(4'h2, 16'h00C0);
    chk(16'(irq[0]), 16'h0001, "R7 write one does not clear");
    wr(4'h2, 16'h0040);
    chk(16'(irq[0]), 16'h0000, "R6 read then write zero clears");
    wr(4'h2, 16'h00C0);
    chk(16'(irq[0]), 16'h0000, "R7 write one does not set");
    rd(4'h2, 16'h0040, "R7 flag still clear");

    // R9 unused bits
    wr(4'h2, 16'hFF3D);
    rd(4'h2, 16'h0001, "R9 unused bits dropped");
    wr(4'h2, 16'hFFFE);
    rd(4'h2, 16'h0042, "R9 mask with bit 7 written one");

    // R2 prescaler restarts from zero
    wr(4'h2, 16'h0040);
    wr(4'h6, 16'h0000);
    wr(4'h0, 16'h0001);
    idle(5);
    wr(4'h0, 16'h0000);
    wr(4'h0, 16'h0001);          // edge S
    idle(7);
    chk(16'(irq[0]), 16'h0000, "R2 full prescale after restart");
    idle(1);
    chk(16'(irq[0]), 16'h0001, "R2 tick after full prescale");

    // R8 match and clear in the same cycle (matches every 8 edges from S)
    rd(4'h2, 16'h00C0, "R8 arm read");          // S+9
    idle(6);                                    // S+15
    wr(4'h2, 16'h0040);                         // S+16 = match
    chk(16'(irq[0]), 16'h0001, "R8 match wins over clear");
    wr(4'h2, 16'h0040);                         // S+17
    chk(16'(irq[0]), 16'h0001, "R6 match withdraws permission");
    rd(4'h2, 16'h00C0, "R6 re-arm read");       // S+18
    wr(4'h2, 16'h0040);                         // S+19
    chk(16'(irq[0]), 16'h0001 ^ 16'h0001, "R6 clear after fresh read");
    wr(4'h0, 16'h0000);
    idle(10);
    chk(16'(irq[0]), 16'h0000, "R2 stopped channel stays quiet");

    // R3 divider 512, compare 0
    wr(4'h2, 16'h0043);
    wr(4'h0, 16'h0001);
    idle(511);
    chk(16'(irq[0]), 16'h0000, "R3 ratio 512 before");
    idle(1);
    chk(16'(irq[0]), 16'h0001, "R3 ratio 512 period");
    wr(4'h0, 16'h0000);

    // R11 / R3: channel 1 alone, divider 32, compare 1
    wr(4'h8, 16'h0041);
    wr(4'hC, 16'h0001);
    wr(4'hA, 16'h0000);
    wr(4'h0, 16'h0002);
    idle(63);
    chk(16'(irq[1]), 16'h0000, "R3 ratio 32 before");
    idle(1);
    chk(16'(irq[1]), 16'h0001, "R11 channel 1 period");
    chk(16'(irq[0]), 16'h0001, "R11 channel 0 flag untouched");
    rd(4'h4, 16'h0000, "R11 channel 0 counter held");
    rd(4'h0, 16'h0002, "R1 run bits readback");
    wr(4'h0, 16'h0000);
    rd(4'h8, 16'h00C1, "R11 channel 1 control");

    idle(4);
    chk(16'(sb.size()), 16'h0000, "R1 all reads returned");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule